// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counter timer on a simple synchronous register bus. Software stores a limit value, selects a counting mode, and later reads back the live count and the interrupt status. The count falls by one on every prescaled tick while the timer is enabled. A timer clock-enable input, `tick_en`, supplies the base ticks, and the prescaler passes either every tick, one in sixteen or one in 256. When the count passes from one to zero, a raw interrupt flag is set. That flag drives one level interrupt output, gated by an enable bit.

The counter restarts in one of three ways. In periodic mode it reloads from the stored limit. In free-running mode it reloads from the all-ones value of the selected width (16 or 32 bits). In one-shot mode it parks at zero. Two addresses write the limit. One also loads the counter at once. The other only changes the value used at the next reload, so a running period can be retuned without a glitch.

The bus uses a 3-bit word index. A write is taken on the clock edge when `bus_we` is high, and read data is combinational from `bus_addr`.

Top module: `dcount_timer`

## Requirements
- R1: After reset the control register reads 0x20, and the limit, the count, both status reads and `irq_o` are all zero.
- R2: A write to index 0 stores the limit. From the next cycle the counter holds the written value, masked to the current width. Indexes 0 and 6 both read back the full 32-bit limit.
- R3: A write to index 6 stores the limit and leaves the count unchanged.
- R4: Writes to the value register (index 1) have no effect. Reads of index 3 and index 7 return zero.
- R5: The count changes only on a prescaled tick while control bit 7 (enable) is set. With the enable clear, the count holds.
- R6: Control bits [3:2] choose the prescale: 00 passes every `tick_en`, 01 passes one in 16, 10 passes one in 256, and 11 acts like 00. Any control write restarts the prescale phase.
- R7: A tick at a count of 1 sets the raw flag and leaves the count at 0. A tick at a count of 0 reloads the counter. When control bit 6 (periodic) is set it loads the limit masked to the width. When bit 6 is clear it loads the all-ones value of the width.
- R8: With control bit 0 (one-shot) set, a tick at a count of 0 leaves it at 0 and raises no flag.
- R9: With control bit 1 (wide) clear, the counter is 16 bits wide and bits 31:16 of the value read are zero. With bit 1 set, it is 32 bits wide.
- R10: Any write to index 3 clears the raw flag. An expiry in the same cycle wins, and the flag stays set.
- R11: Index 4 reads the raw flag in bit 0. Index 5 and `irq_o` both give the raw flag ANDed with control bit 5 (interrupt enable).
- R12: Index 2 reads back the low 8 bits last written to the control register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Base timer tick, one clock wide per tick |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt: raw flag AND interrupt enable |

## Verification
The assertions check the rules that hold on every cycle:
- the interrupt is held low while its enable is clear;
- an expiry sets the flag, and a clear without an expiry drops it;
- the upper half reads zero in narrow mode;
- the count holds while disabled, or after a background load;
- a load write takes effect at once;
- one-shot mode parks at zero;
- no step occurs without a tick.

Exact prescale phases, the reload values of each mode and the tick on which each expiry occurs show up only in the bench's scenarios. There, a behavioural model is compared with the read data and the interrupt on every clock.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int PRE_W    = 8;
  localparam int REG_AW   = 3;
  localparam int CTRL_W   = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  typedef enum logic [REG_AW-1:0] {
    SEL_LIMIT_NOW  = 3'd0,
    SEL_COUNT      = 3'd1,
    SEL_MODE       = 3'd2,
    SEL_FLAG_CLR   = 3'd3,
    SEL_FLAG_RAW   = 3'd4,
    SEL_FLAG_MASK  = 3'd5,
    SEL_LIMIT_NEXT = 3'd6,
    SEL_SPARE      = 3'd7
  } reg_sel_e;

  // Bit 7 down to bit 0 of the control word.
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] presc;
    logic       wide;
    logic       oneshot;
  } mode_t;

  // Terminal value of the prescale phase counter.
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] code);
    case (code)
      2'b01:   return PRE_W'(15);
      2'b10:   return PRE_W'(255);
      default: return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] width_mask(input logic wide);
    return wide ? {CNT_W{1'b1}} : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  function automatic logic [CNT_W-1:0] reload_value(input logic periodic,
                                                    input logic wide,
                                                    input logic [CNT_W-1:0] limit);
    return periodic ? (limit & width_mask(wide)) : width_mask(wide);
  endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       step
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = presc_last(code);
    step = run && (phase_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= (phase_q == last) ? '0 : phase_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             oneshot,
  input  logic             wide,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             at_zero, at_one;

  always_comb begin
    mask    = width_mask(wide);
    cnt_val = cnt_q & mask;
    at_zero = (cnt_val == '0);
    at_one  = (cnt_val == CNT_W'(1));
    expire  = step && !load_wr && at_one;
    cnt_d   = cnt_q;
    if (load_wr) begin
      cnt_d = load_data & mask;
    end else if (step) begin
      if (at_zero) cnt_d = oneshot ? '0 : reload_val;
      else         cnt_d = cnt_val - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);

  reg_sel_e         sel;
  logic             load_wr, bg_wr, ctrl_wr, clr_wr;
  mode_t            mode_q;
  logic [CNT_W-1:0] limit_q;
  logic             raw_q;
  logic             step, expire;
  logic [CNT_W-1:0] cnt_val, reload_val;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    load_wr = bus_we && (sel == SEL_LIMIT_NOW);
    bg_wr   = bus_we && (sel == SEL_LIMIT_NEXT);
    ctrl_wr = bus_we && (sel == SEL_MODE);
    clr_wr  = bus_we && (sel == SEL_FLAG_CLR);
    reload_val = reload_value(mode_q.periodic, mode_q.wide, limit_q);
  end

  dct_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_q.run && tick_en),
    .restart (ctrl_wr),
    .code    (mode_q.presc),
    .step    (step)
  );

  dct_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .load_wr    (load_wr),
    .load_data  (bus_wdata),
    .oneshot    (mode_q.oneshot),
    .wide       (mode_q.wide),
    .reload_val (reload_val),
    .cnt_val    (cnt_val),
    .expire     (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= mode_t'(CTRL_RESET);
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (ctrl_wr)          mode_q  <= mode_t'(bus_wdata[CTRL_W-1:0]);
      if (load_wr || bg_wr) limit_q <= bus_wdata;
      if (expire)           raw_q   <= 1'b1;
      else if (clr_wr)      raw_q   <= 1'b0;
    end
  end

  assign irq_o = raw_q && mode_q.irq_en;

  always_comb begin
    case (sel)
      SEL_LIMIT_NOW,
      SEL_LIMIT_NEXT: bus_rdata = limit_q;
      SEL_COUNT:      bus_rdata = cnt_val;
      SEL_MODE:       bus_rdata = CNT_W'(mode_q);
      SEL_FLAG_RAW:   bus_rdata = CNT_W'(raw_q);
      SEL_FLAG_MASK:  bus_rdata = CNT_W'(raw_q && mode_q.irq_en);
      default:        bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             run,
  input logic             oneshot,
  input logic             wide,
  input logic             irq_en,
  input logic             step,
  input logic             expire,
  input logic             load_wr,
  input logic             bg_wr,
  input logic             ctrl_wr,
  input logic             clr_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt_val,
  input logic             raw,
  input logic             irq
);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R11
  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) expire |=> raw); // R7
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !expire) |=> !raw); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !wide |-> (cnt_val[CNT_W-1:NARROW_W] == '0)); // R9
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load_wr && !ctrl_wr) |=> $stable(cnt_val)); // R5
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) step |-> (tick_en && run)); // R6
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n) (step && oneshot && cnt_val == '0 && !load_wr && !ctrl_wr) |=> (cnt_val == '0)); // R8
  AST_LOAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n) (load_wr && wide && !ctrl_wr) |=> (cnt_val == $past(wdata))); // R2
  AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (bg_wr && !step && !ctrl_wr) |=> $stable(cnt_val)); // R3

endmodule

bind dcount_timer dct_checker u_dct_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .run     (mode_q.run),
  .oneshot (mode_q.oneshot),
  .wide    (mode_q.wide),
  .irq_en  (mode_q.irq_en),
  .step    (step),
  .expire  (expire),
  .load_wr (load_wr),
  .bg_wr   (bg_wr),
  .ctrl_wr (ctrl_wr),
  .clr_wr  (clr_wr),
  .wdata   (bus_wdata),
  .cnt_val (cnt_val),
  .raw     (raw_q),
  .irq     (irq_o)
);

// File: tb/test_dcount_timer.sv
module test_dcount_timer;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int    n_tests = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference state
  longint m_cnt = 0;
  longint m_limit = 0;
  int     m_ctrl = 'h20;
  int     m_raw = 0;
  int     m_phase = 0;

  always #(PERIOD/2) clk = ~clk;

  dcount_timer i_dcount_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic longint span(input int ctrl);
    return ((ctrl >> 1) & 1) ? 64'hFFFF_FFFF : 64'hFFFF;
  endfunction

  function automatic longint model_read(input int a);
    case (a)
      0, 6: return m_limit;
      1: return m_cnt & span(m_ctrl);
      2: return m_ctrl;
      4: return m_raw;
      5: return ((m_ctrl >> 5) & 1) ? m_raw : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_limit = 0; m_ctrl = 'h20; m_raw = 0; m_phase = 0;
    end else begin
      int divide, a;
      bit stepped, fired;
      longint cur, wrap_to, msk;
      a = int'(bus_addr);
      stepped = 0; fired = 0;
      case ((m_ctrl >> 2) & 3)
        1: divide = 16;
        2: divide = 256;
        default: divide = 1;
      endcase
      if (((m_ctrl >> 7) & 1) && tick_en) begin
        m_phase = m_phase + 1;
        if (m_phase >= divide) begin stepped = 1; m_phase = 0; end
      end
      if (bus_we && a == 2) m_phase = 0;
      msk = span(m_ctrl);
      cur = m_cnt & msk;
      wrap_to = ((m_ctrl >> 6) & 1) ? (m_limit & msk) : msk;
      if (bus_we && a == 0) m_cnt = longint'(bus_wdata) & msk;
      else if (stepped) begin
        if (cur == 0) m_cnt = (m_ctrl & 1) ? 0 : wrap_to;
        else begin m_cnt = cur - 1; fired = (cur == 1); end
      end
      if (fired) m_raw = 1;
      else if (bus_we && a == 3) m_raw = 0;
      if (bus_we && a == 2) m_ctrl = int'(bus_wdata[7:0]);
      if (bus_we && (a == 0 || a == 6)) m_limit = longint'(bus_wdata);
    end
    if (rst_n && !finished) begin
      #(PERIOD/4);
      n_tests++;
      if (longint'(bus_rdata) != model_read(int'(bus_addr)) ||
          irq_o != (((m_ctrl >> 5) & 1) && m_raw)) begin
        n_fail++;
        $display("FAIL %s model compare idx %0d: rdata=%h irq=%0b expected rdata=%h irq=%0b",
                 cur_req, bus_addr, bus_rdata, irq_o, model_read(int'(bus_addr)),
                 ((m_ctrl >> 5) & 1) && m_raw);
      end
    end
  end

  task automatic chk(input string req, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint got, input longint lo, input longint hi);
    n_tests++;
    if (got < lo || got > hi) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h..%h", req, got, lo, hi);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk);
    bus_addr = 3'(a);
    #(PERIOD/4);
    v = longint'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint v, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rd(2, v); chk("R1 ctrl reset", v, 'h20);
    rd(1, v); chk("R1 count reset", v, 0);
    rd(0, v); chk("R1 limit reset", v, 0);
    rd(4, v); chk("R1 raw reset", v, 0);
    chk("R1 irq reset", irq_o, 0);

    cur_req = "R9";
    wr(0, 32'h1234_5678);
    rd(1, v); chk("R9 narrow load masked", v, 'h5678);
    cur_req = "R2";
    rd(0, v); chk("R2 limit readback", v, 'h1234_5678);
    rd(6, v); chk("R2 bg index readback", v, 'h1234_5678);
    wr(2, 32'h22);
    wr(0, 32'hCAFE_0005);
    rd(1, v); chk("R2 wide load immediate", v, 'hCAFE_0005);

    cur_req = "R3";
    wr(6, 32'd7);
    rd(1, v); chk("R3 bg load leaves count", v, 'hCAFE_0005);
    rd(0, v); chk("R3 bg load stores limit", v, 7);

    cur_req = "R4";
    wr(1, 32'h111);
    rd(1, v); chk("R4 value write ignored", v, 'hCAFE_0005);
    rd(3, v); chk("R4 clear index reads zero", v, 0);
    rd(7, v); chk("R4 spare index reads zero", v, 0);

    cur_req = "R5";
    idle(10);
    rd(1, v); chk("R5 disabled holds", v, 'hCAFE_0005);

    cur_req = "R7";
    wr(0, 32'd4);
    wr(2, 32'hE2);
    rd(2, v); chk("R12 ctrl readback", v, 'hE2);
    for (int i = 0; i < 30 && !irq_o; i++) @(negedge clk);
    chk("R11 irq raised on expiry", irq_o, 1);
    rd(4, v); chk("R11 raw status", v, 1);
    rd(5, v); chk("R11 masked status", v, 1);
    for (int i = 0; i < 12; i++) begin
      rd(1, v); chk_rng("R7 periodic stays within limit", v, 0, 4);
    end

    cur_req = "R11";
    wr(2, 32'h62);
    wr(2, 32'h42);
    rd(5, v); chk("R11 masked zero when ie clear", v, 0);
    chk("R11 irq low when ie clear", irq_o, 0);
    rd(4, v); chk("R11 raw still set", v, 1);
    cur_req = "R10";
    wr(3, 32'h0);
    rd(4, v); chk("R10 clear drops raw", v, 0);

    cur_req = "R8";
    wr(0, 32'd3);
    wr(2, 32'hA3);
    idle(20);
    rd(1, v); chk("R8 one-shot parks at zero", v, 0);
    rd(4, v); chk("R8 one-shot flagged once", v, 1);
    wr(3, 32'h0);
    idle(20);
    rd(4, v); chk("R8 no repeat flag", v, 0);
    rd(1, v); chk("R8 still zero", v, 0);

    cur_req = "R7";
    wr(2, 32'h20);
    wr(0, 32'd2);
    wr(2, 32'hA0);
    idle(10);
    rd(1, v); chk_rng("R7 free-run narrow wraps to 0xFFFF", v, 'hFFF0, 'hFFFF);
    rd(4, v); chk("R7 free-run flag", v, 1);
    wr(2, 32'h20);
    wr(3, 32'h0);
    wr(2, 32'h22);
    wr(0, 32'd1);
    wr(2, 32'hA2);
    idle(10);
    rd(1, v); chk_rng("R7 free-run wide wraps to all ones", v, 'hFFFF_FFF0, 'hFFFF_FFFF);

    cur_req = "R6";
    wr(2, 32'h22); wr(0, 32'd1000); wr(2, 32'hA6);
    idle(160);
    rd(1, v); chk_rng("R6 divide by 16", 1000 - v, 9, 11);
    wr(2, 32'h22); wr(0, 32'd1000); wr(2, 32'hAA);
    idle(600);
    rd(1, v); chk_rng("R6 divide by 256", 1000 - v, 1, 3);
    wr(2, 32'h22); wr(0, 32'd1000); wr(2, 32'hAE);
    idle(20);
    rd(1, v); chk_rng("R6 code 11 divides by 1", 1000 - v, 19, 22);
    rd(2, v); chk("R12 ctrl readback code 11", v, 'hAE);

    cur_req = "R5";
    tick_en = 1'b0;
    rd(1, base);
    idle(8);
    rd(1, v); chk("R5 no tick no step", v, base);
    tick_en = 1'b1;

    idle(4);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule